// File: doc/BRIEF.md
# Prescaled Interval Timer with Processor Stall Request

This block is a register-programmed interval timer for a small embedded processor. Software writes a 4-bit prescale code and a 12-bit timeout into a configuration register. It then sets a run bit in a control register. A short fixed lead-in follows. After it, a 12-bit up-counter advances once every 2·N master-clock cycles, where N is the divisor picked by the prescale code. When the count reaches the timeout, a sticky completion flag sets. Software can poll that flag through the control register or watch the dedicated `done` pin.

From enable to completion the interval is exactly 2·N·TO + 3 master-clock cycles. The timer can also stall the processor. If the stall-enable bit is set in the same write as the run bit, or in any later write while the interval is still running, the block raises a stall request. That request falls in the same cycle the completion flag sets, so the processor resumes at the next instruction. The processor core, the oscillator and clock selection sit outside this block.

The register bus is a plain single-cycle write port plus a combinational read port. It carries control and status only, so there is no valid/ready handshake and no back-pressure.

Top module: `interval_timer`

## Requirements
- R1: After reset, the run bit, stall-enable bit, completion flag, prescale code, timeout and `halt_req` are all 0.
- R2: Register map and write rules:
  - The control register is at address 20h: bit 0 is run, bit 1 is stall-enable, bit 2 reads the completion flag.
  - Writing 1 to bit 2 of the control register clears the completion flag.
  - The configuration register is at address 21h: bits 11:0 are the timeout TO and bits 15:12 are the prescale code.
  - Writes to any other address are ignored, and reads from any other address return 0.
- R3: Let the clock edge that captures a control write changing run from 0 to 1 be edge E. The completion flag is 0 after every earlier edge up to E+K−1 and 1 after edge E+K, where K = 2·N·TO + 3.
- R4: The divisor N depends on the prescale code c. For c = 0..7, N = 2^c. For c = 8..15, N = 3·2^(c−8).
- R5: When TO = 0, the completion flag sets 3 cycles after enable, whatever the prescale code.
- R6: Once set, the completion flag stays set and counting stops. After a clear through control bit 2, the flag stays 0 and does not set again unless the timer is re-enabled.
- R7: A control write that changes run from 0 to 1 clears the completion flag at that edge and restarts the interval from zero.
- R8: `halt_req` is 1 while stall-enable is set and the interval is in progress. The stall-enable may have been written together with run or later. `halt_req` returns to 0 at the same edge at which the completion flag sets.
- R9: A control write with run = 1 while run is already 1 does not restart the interval.
- R10: Writing run = 0 stops the interval, and the completion flag does not set while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| halt_req | output | 1 | Processor stall request |
| done | output | 1 | Sticky completion flag |

## Verification
The assertions assume that the configuration register is not rewritten while an interval is running. The bound on the counter against the timeout depends on that. The bench keeps to this rule by loading the configuration only while the timer is disabled or has completed. The assertions also assume that only control writes clear the completion flag. The bench therefore never pulses reset mid-run and never writes the control register during a completion check that relies on the flag staying set.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CNT_W    = 12;
  localparam int PS_W     = 4;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int LEAD_CYC = 3;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h20;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 8'h21;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_RUN  = 2'd2,
    PH_HOLD = 2'd3
  } phase_t;

  // divisor for a prescale code: powers of two, then three times powers of two
  function automatic int unsigned half_period(input logic [PS_W-1:0] code);
    if (int'(code) < 8) return 32'd1 << int'(code);
    else                return 32'd3 << (int'(code) - 8);
  endfunction

  localparam int unsigned MAX_HALF = half_period({PS_W{1'b1}});
  localparam int PRE_W = $clog2(2 * MAX_HALF);
endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale
  import itmr_pkg::*;
#(
  parameter int P_PS_W  = PS_W,
  parameter int P_PRE_W = PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [P_PS_W-1:0] code,
  output logic              tick
);
  logic [P_PRE_W-1:0] acc_q;
  logic [P_PRE_W-1:0] last;

  // one count step every 2*N master cycles
  always_comb begin
    last = P_PRE_W'(2 * half_period(code) - 1);
    tick = run && (acc_q == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (run)   acc_q <= tick ? '0 : acc_q + 1'b1;
  end
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int P_CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  input  logic [P_CNT_W-1:0] limit,
  output logic [P_CNT_W-1:0] value,
  output logic               hit
);
  always_comb hit = tick && ((value + P_CNT_W'(1)) == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (clear) value <= '0;
    else if (tick)  value <= value + 1'b1;
  end
endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_PS_W   = PS_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [P_ADDR_W-1:0] addr,
  input  logic [P_DATA_W-1:0] wdata,
  output logic [P_DATA_W-1:0] rdata,
  input  logic                hit,
  output logic [P_CNT_W-1:0]  timeout,
  output logic [P_PS_W-1:0]   code,
  output logic                launch,
  output logic                counting,
  output logic                en,
  output logic                done,
  output logic                halt_req
);
  localparam int LEAD_W = $clog2(LEAD_CYC);

  phase_t              phase_q;
  logic [LEAD_W-1:0]   lead_q;
  logic                en_q, hen_q, done_q;
  logic [P_CNT_W-1:0]  to_q;
  logic [P_PS_W-1:0]   code_q;
  logic                ctrl_wr, cfg_wr;

  always_comb begin
    ctrl_wr = wr && (addr == CTRL_ADDR);
    cfg_wr  = wr && (addr == CFG_ADDR);
    launch  = ctrl_wr && wdata[0] && !en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      lead_q  <= '0;
      en_q    <= 1'b0;
      hen_q   <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= '0;
      code_q  <= '0;
    end else begin
      if (cfg_wr) {code_q, to_q} <= wdata[P_PS_W+P_CNT_W-1:0];
      if (ctrl_wr) begin
        en_q  <= wdata[0];
        hen_q <= wdata[1];
        if (wdata[2]) done_q <= 1'b0;
      end
      if (ctrl_wr && !wdata[0]) begin
        phase_q <= PH_IDLE;
      end else if (launch) begin
        phase_q <= PH_LEAD;
        lead_q  <= '0;
        done_q  <= 1'b0;
      end else begin
        case (phase_q)
          PH_LEAD: begin
            if (lead_q == LEAD_W'(LEAD_CYC - 1)) begin
              if (to_q == '0) begin
                done_q  <= 1'b1;
                phase_q <= PH_HOLD;
              end else begin
                phase_q <= PH_RUN;
              end
            end else begin
              lead_q <= lead_q + 1'b1;
            end
          end
          PH_RUN: begin
            if (hit) begin
              done_q  <= 1'b1;
              phase_q <= PH_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR)     rdata[2:0] = {done_q, hen_q, en_q};
    else if (addr == CFG_ADDR) rdata[P_PS_W+P_CNT_W-1:0] = {code_q, to_q};
    timeout  = to_q;
    code     = code_q;
    counting = (phase_q == PH_RUN);
    en       = en_q;
    done     = done_q;
    halt_req = hen_q && ((phase_q == PH_LEAD) || (phase_q == PH_RUN));
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_PS_W   = PS_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  output logic                halt_req,
  output logic                done
);
  logic [P_CNT_W-1:0] timeout;
  logic [P_CNT_W-1:0] cnt_val;
  logic [P_PS_W-1:0]  code;
  logic               launch, counting, tmr_en, tick, hit;

  itmr_ctrl #(
    .P_CNT_W(P_CNT_W), .P_PS_W(P_PS_W), .P_ADDR_W(P_ADDR_W), .P_DATA_W(P_DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .hit(hit), .timeout(timeout), .code(code),
    .launch(launch), .counting(counting), .en(tmr_en), .done(done),
    .halt_req(halt_req)
  );

  itmr_prescale #(.P_PS_W(P_PS_W), .P_PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(launch), .run(counting),
    .code(code), .tick(tick)
  );

  itmr_count #(.P_CNT_W(P_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(launch), .tick(tick),
    .limit(timeout), .value(cnt_val), .hit(hit)
  );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker
  import itmr_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [P_ADDR_W-1:0] bus_addr,
  input logic [P_DATA_W-1:0] bus_wdata,
  input logic                halt_req,
  input logic                done,
  input logic                tmr_en,
  input logic                counting,
  input logic [P_CNT_W-1:0]  cnt_val,
  input logic [P_CNT_W-1:0]  timeout
);
  logic ctrl_wr;
  always_comb ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr) |=> done);

  assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr) |=> $stable(cnt_val));

  assert_stall_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !done);

  assert_stall_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(halt_req)) |-> !halt_req);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[0] && !tmr_en) |=> !done);

  assert_done_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tmr_en));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (cnt_val < timeout));
endmodule

bind interval_timer itmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .halt_req(halt_req), .done(done), .tmr_en(tmr_en),
  .counting(counting), .cnt_val(cnt_val), .timeout(timeout)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_CFG  = 8'h21;
  localparam int NV = 18;
  // {stall, code, timeout}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'd0,  12'd5}, {1'b1, 4'd1,  12'd1}, {1'b0, 4'd2,  12'd2},
    {1'b1, 4'd3,  12'd3}, {1'b0, 4'd4,  12'd4}, {1'b1, 4'd5,  12'd5},
    {1'b0, 4'd6,  12'd1}, {1'b1, 4'd7,  12'd2}, {1'b0, 4'd8,  12'd3},
    {1'b1, 4'd9,  12'd4}, {1'b0, 4'd10, 12'd5}, {1'b1, 4'd11, 12'd1},
    {1'b0, 4'd12, 12'd2}, {1'b1, 4'd13, 12'd3}, {1'b0, 4'd14, 12'd4},
    {1'b1, 4'd15, 12'd1}, {1'b1, 4'd0,  12'd4095}, {1'b0, 4'd2, 12'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        halt_req, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt_req(halt_req), .done(done)
  );

  function automatic int exp_div(input int c);
    return (c < 8) ? (1 << c) : (3 << (c - 8));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    t0 = cyc;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_done(input int lim, output int took);
    while (!done && (cyc - t0) < lim) @(negedge clk);
    took = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog R3 actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int took, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, rd);
    chk(rd == 16'h0 && !done && !halt_req, "R1 reset control", int'(rd), 0);
    bus_read(A_CFG, rd);
    chk(rd == 16'h0, "R1 reset config", int'(rd), 0);

    // R2 map, readback and unmapped writes
    bus_write(A_CFG, 16'h3ABC);
    bus_read(A_CFG, rd);
    chk(rd == 16'h3ABC, "R2 config readback", int'(rd), 16'h3ABC);
    bus_write(8'h22, 16'hFFFF);
    bus_read(A_CFG, rd);
    chk(rd == 16'h3ABC, "R2 unmapped write ignored", int'(rd), 16'h3ABC);
    bus_read(A_CTRL, rd);
    chk(rd == 16'h0 && !done, "R2 unmapped write leaves control", int'(rd), 0);
    bus_read(8'h22, rd);
    chk(rd == 16'h0, "R2 unmapped read", int'(rd), 0);

    // R3 R4 R8 vector walk over every prescale code
    for (int i = 0; i < NV; i++) begin
      logic hb;
      int c, to;
      hb = VEC[i][16];
      c  = int'(VEC[i][15:12]);
      to = int'(VEC[i][11:0]);
      k  = 2 * exp_div(c) * to + 3;
      bus_write(A_CTRL, 16'h0);
      bus_write(A_CFG, VEC[i][15:0]);
      bus_write(A_CTRL, hb ? 16'h3 : 16'h1);
      chk(halt_req == hb, "R8 stall at start", int'(halt_req), int'(hb));
      wait_done(k + 10, took);
      chk(took == k, "R3 R4 interval", took, k);
      chk(!halt_req, "R8 stall released", int'(halt_req), 0);
    end

    // R5 zero timeout at the largest divisor
    bus_write(A_CTRL, 16'h0);
    bus_write(A_CFG, 16'hF000);
    bus_write(A_CTRL, 16'h1);
    wait_done(20, took);
    chk(took == 3, "R5 zero timeout", took, 3);

    // R6 sticky flag, readback, then clear stops for good
    repeat (30) @(negedge clk);
    bus_read(A_CTRL, rd);
    chk(done && rd[2], "R6 flag held", int'(rd), 5);
    bus_write(A_CTRL, 16'h5);
    chk(!done, "R6 clear by write", int'(done), 0);
    repeat (40) @(negedge clk);
    chk(!done && !halt_req, "R6 no further completion", int'(done), 0);

    // R7 re-enable restarts (code 1, TO 3: K = 15)
    bus_write(A_CFG, 16'h1003);
    bus_write(A_CTRL, 16'h0);
    bus_write(A_CTRL, 16'h1);
    wait_done(30, took);
    chk(took == 15, "R7 restart interval", took, 15);
    bus_write(A_CTRL, 16'h0);
    chk(done, "R7 disable keeps flag", int'(done), 1);
    bus_write(A_CTRL, 16'h1);
    chk(!done, "R7 enable clears flag", int'(done), 0);
    wait_done(30, took);
    chk(took == 15, "R7 second interval", took, 15);

    // R9 rewrite of run does not restart; late stall-enable R8
    bus_write(A_CTRL, 16'h0);
    bus_write(A_CTRL, 16'h1);
    k = t0;
    bus_write(A_CTRL, 16'h3);
    chk(halt_req, "R8 late stall enable", int'(halt_req), 1);
    t0 = k;
    wait_done(30, took);
    chk(took == 15, "R9 no restart", took, 15);
    chk(!halt_req, "R8 late stall released", int'(halt_req), 0);

    // R10 disable mid interval
    bus_write(A_CTRL, 16'h0);
    bus_write(A_CTRL, 16'h1);
    bus_write(A_CTRL, 16'h0);
    chk(!done, "R10 flag clear after start", int'(done), 0);
    repeat (40) @(negedge clk);
    chk(!done, "R10 no completion while disabled", int'(done), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule